// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the byte-wide register front end of one unit of a cascadable programmable interrupt controller. Software reaches it through two addresses, a command port and a data port, plus a separate select for a per-pin trigger-mode register. The block decodes the initialization word sequence and the operation command words. It holds the programmed state: vector base, interrupt mask, automatic end-of-interrupt, nested mode, special mask mode and read selection. It returns read data and carries out poll-mode reads.

Priority arbitration lives in a separate core. The core supplies its request and in-service registers, along with the current winning pin. In return, this block sends single-cycle strobes toward the core for re-initialization, for end-of-interrupt and priority commands, and for poll acknowledgement. On the re-initialization strobe the core clears its request register and resets its lowest-priority pointer to 7.

The parameter `IS_PRIMARY` selects whether the unit is the primary or the secondary of a cascade pair. This changes the nested-mode handling and the writable bits of the trigger register.

Top module: `pic_cmd_regif`

## Requirements
- R1: After reset the interrupt mask reads 0xFF, the trigger register is 0, and ready, error, mode flags and all strobes are 0.
- R2: A command-port write with bit 4 set starts initialization. It clears ready, mask, read selection, poll and special mask. It pulses `init_stb` for one cycle and moves the sequence to the vector-base step.
- R3: In that starting word, bit 1 must be 0 and bit 0 must be 1. Otherwise `cfg_err` is set and the sequence stops with ready still 0, so that later data-port writes load the mask.
- R4: The first data-port write of the sequence stores the vector base as the value AND 0xF8. The second is accepted and has no effect on any output.
- R5: In the third data-port write, bit 0 must be 1, otherwise `cfg_err` is set and ready stays 0. If bit 0 is 1, bit 1 loads `auto_eoi`, bit 4 loads `nested_mode` only when `IS_PRIMARY` is 1, and ready becomes 1.
- R6: A data-port write outside the initialization sequence loads the 8-bit mask.
- R7: When ready, a command-port write with bits 4 and 3 clear pulses `cmd_stb` in the next cycle with rotate = bit 7, specific = bit 6, eoi = bit 5 and level = bits [2:0]. When not ready, no strobe is produced.
- R8: When ready, a command-port write with bit 3 set and bit 4 clear is a mode command. Bit 6 enables bit 5 to load `spec_mask`. Bit 1 enables bit 0 to load `sel_isr` and bit 2 to load the poll request.
- R9: A read with poll pending clears poll. If the core reports a winner, the read returns 0x80 OR the pin and pulses `ack_stb` with `ack_pin`; otherwise it returns 0x00 with no acknowledge.
- R10: Without poll, `rdata` is valid the cycle after `rd_en`. The data port returns the mask. The command port returns the core's in-service register if `sel_isr` is 1, and its request register otherwise.
- R11: A write with `elc_sel` stores the value AND 0xF8 on the primary unit or AND 0xDE on the secondary unit. A read with `elc_sel` returns the stored value.
- R12: `cfg_err` stays set until the next initialization-start write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 0 selects the command port, 1 selects the data port |
| elc_sel | input | 1 | Selects the trigger-mode register instead of the ports |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| core_irr | input | 8 | Request register from the core |
| core_isr | input | 8 | In-service register from the core |
| win_valid | input | 1 | Core has an eligible pending pin |
| win_pin | input | 3 | Pin the core would grant |
| rdata | output | 8 | Read data, registered |
| vec_base | output | 8 | Programmed vector base |
| int_mask | output | 8 | Interrupt mask |
| trig_level | output | 8 | Per-pin level-trigger bits |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| nested_mode | output | 1 | Special nested mode (primary only) |
| spec_mask | output | 1 | Special mask mode |
| sel_isr | output | 1 | Command-port read selects the in-service register |
| ready | output | 1 | Initialization complete |
| cfg_err | output | 1 | Sticky initialization error |
| init_stb | output | 1 | Re-initialization pulse toward the core |
| cmd_stb | output | 1 | End-of-interrupt or priority command pulse |
| cmd_rotate | output | 1 | Command rotate bit |
| cmd_specific | output | 1 | Command specific-level bit |
| cmd_eoi | output | 1 | Command end-of-interrupt bit |
| cmd_level | output | 3 | Command level |
| ack_stb | output | 1 | Poll acknowledge pulse |
| ack_pin | output | 3 | Acknowledged pin |

## Verification
The bench builds two instances that share one bus: one with `IS_PRIMARY` = 1 and one with `IS_PRIMARY` = 0. Every write sequence therefore drives both units at once. The nested-mode bit of the last initialization word can be compared between the two instances in a single step. The same holds for the two trigger-register write masks, 0xF8 and 0xDE.

// File: rtl/pic_cmd_regif.sv
module pic_cmd_regif #(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       elc_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  input  logic [7:0] core_irr,
  input  logic [7:0] core_isr,
  input  logic       win_valid,
  input  logic [2:0] win_pin,
  output logic [7:0] rdata,
  output logic [7:0] vec_base,
  output logic [7:0] int_mask,
  output logic [7:0] trig_level,
  output logic       auto_eoi,
  output logic       nested_mode,
  output logic       spec_mask,
  output logic       sel_isr,
  output logic       ready,
  output logic       cfg_err,
  output logic       init_stb,
  output logic       cmd_stb,
  output logic       cmd_rotate,
  output logic       cmd_specific,
  output logic       cmd_eoi,
  output logic [2:0] cmd_level,
  output logic       ack_stb,
  output logic [2:0] ack_pin
);
  localparam logic [7:0] TRIG_WMASK = IS_PRIMARY ? 8'hF8 : 8'hDE;
  localparam logic [7:0] BASE_MASK  = 8'hF8;

  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_CASC, ST_MODE} step_t;

  step_t step;
  logic  poll;

  wire cmd_wr   = wr_en && !elc_sel && !addr;
  wire data_wr  = wr_en && !elc_sel && addr;
  wire init_wr  = cmd_wr && wdata[4];
  wire op_wr    = cmd_wr && !wdata[4] && ready;
  wire port_rd  = rd_en && !wr_en && !elc_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step         <= ST_IDLE;
      poll         <= 1'b0;
      rdata        <= 8'h00;
      vec_base     <= 8'h00;
      int_mask     <= 8'hFF;
      trig_level   <= 8'h00;
      auto_eoi     <= 1'b0;
      nested_mode  <= 1'b0;
      spec_mask    <= 1'b0;
      sel_isr      <= 1'b0;
      ready        <= 1'b0;
      cfg_err      <= 1'b0;
      init_stb     <= 1'b0;
      cmd_stb      <= 1'b0;
      cmd_rotate   <= 1'b0;
      cmd_specific <= 1'b0;
      cmd_eoi      <= 1'b0;
      cmd_level    <= 3'd0;
      ack_stb      <= 1'b0;
      ack_pin      <= 3'd0;
    end else begin
      init_stb <= 1'b0;
      cmd_stb  <= 1'b0;
      ack_stb  <= 1'b0;

      if (wr_en && elc_sel)
        trig_level <= wdata & TRIG_WMASK;

      if (init_wr) begin
        ready     <= 1'b0;
        int_mask  <= 8'h00;
        sel_isr   <= 1'b0;
        poll      <= 1'b0;
        spec_mask <= 1'b0;
        init_stb  <= 1'b1;
        if (wdata[1] || !wdata[0]) begin
          cfg_err <= 1'b1;
          step    <= ST_IDLE;
        end else begin
          cfg_err <= 1'b0;
          step    <= ST_BASE;
        end
      end else if (op_wr) begin
        if (wdata[3]) begin
          if (wdata[6]) spec_mask <= wdata[5];
          if (wdata[1]) begin
            sel_isr <= wdata[0];
            poll    <= wdata[2];
          end
        end else begin
          cmd_stb      <= 1'b1;
          cmd_rotate   <= wdata[7];
          cmd_specific <= wdata[6];
          cmd_eoi      <= wdata[5];
          cmd_level    <= wdata[2:0];
        end
      end

      if (data_wr) begin
        unique case (step)
          ST_BASE: begin
            vec_base <= wdata & BASE_MASK;
            step     <= ST_CASC;
          end
          ST_CASC: step <= ST_MODE;
          ST_MODE: begin
            step <= ST_IDLE;
            if (!wdata[0]) begin
              cfg_err <= 1'b1;
            end else begin
              auto_eoi    <= wdata[1];
              nested_mode <= IS_PRIMARY && wdata[4];
              ready       <= 1'b1;
            end
          end
          default: int_mask <= wdata;
        endcase
      end

      if (rd_en && !wr_en && elc_sel)
        rdata <= trig_level;

      if (port_rd) begin
        if (poll) begin
          poll <= 1'b0;
          if (win_valid) begin
            rdata   <= {5'b10000, win_pin};
            ack_stb <= 1'b1;
            ack_pin <= win_pin;
          end else begin
            rdata <= 8'h00;
          end
        end else if (addr) begin
          rdata <= int_mask;
        end else begin
          rdata <= sel_isr ? core_isr : core_irr;
        end
      end
    end
  end
endmodule

// File: rtl/pic_cmd_regif_chk.sv
module pic_cmd_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr,
  input logic       elc_sel,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] int_mask,
  input logic       ready,
  input logic       cfg_err,
  input logic       init_stb,
  input logic       cmd_stb,
  input logic       ack_stb,
  input logic [2:0] ack_pin
);
  wire start_wr = wr_en && !elc_sel && !addr && wdata[4];

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (!ready && int_mask == 8'h00 && init_stb));

  p_ready_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(wr_en && addr && !elc_sel));

  p_cmd_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(ready));

  p_ack_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> (rdata[7] && rdata[6:3] == 4'b0000 && rdata[2:0] == ack_pin));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !start_wr) |=> cfg_err);
endmodule

bind pic_cmd_regif pic_cmd_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .elc_sel(elc_sel), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .int_mask(int_mask), .ready(ready),
  .cfg_err(cfg_err), .init_stb(init_stb), .cmd_stb(cmd_stb),
  .ack_stb(ack_stb), .ack_pin(ack_pin)
);

// File: tb/tb_pic_cmd_regif.sv
module tb_pic_cmd_regif;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, elc_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] core_irr = 8'h00, core_isr = 8'h00;
  logic       win_valid = 1'b0;
  logic [2:0] win_pin = 3'd0;

  logic [7:0] rdata_p, vec_p, mask_p, trig_p;
  logic       aeoi_p, nest_p, smm_p, sel_p, rdy_p, err_p, init_p;
  logic       cstb_p, crot_p, cspec_p, ceoi_p, ack_p;
  logic [2:0] clvl_p, apin_p;
  logic [7:0] rdata_s, vec_s, mask_s, trig_s;
  logic       aeoi_s, nest_s, smm_s, sel_s, rdy_s, err_s, init_s;
  logic       cstb_s, crot_s, cspec_s, ceoi_s, ack_s;
  logic [2:0] clvl_s, apin_s;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_regif #(.IS_PRIMARY(1'b1)) dut (
    .clk, .rst_n, .addr, .elc_sel, .wr_en, .rd_en, .wdata, .core_irr, .core_isr,
    .win_valid, .win_pin, .rdata(rdata_p), .vec_base(vec_p), .int_mask(mask_p),
    .trig_level(trig_p), .auto_eoi(aeoi_p), .nested_mode(nest_p), .spec_mask(smm_p),
    .sel_isr(sel_p), .ready(rdy_p), .cfg_err(err_p), .init_stb(init_p),
    .cmd_stb(cstb_p), .cmd_rotate(crot_p), .cmd_specific(cspec_p), .cmd_eoi(ceoi_p),
    .cmd_level(clvl_p), .ack_stb(ack_p), .ack_pin(apin_p));

  pic_cmd_regif #(.IS_PRIMARY(1'b0)) dut_sec (
    .clk, .rst_n, .addr, .elc_sel, .wr_en, .rd_en, .wdata, .core_irr, .core_isr,
    .win_valid, .win_pin, .rdata(rdata_s), .vec_base(vec_s), .int_mask(mask_s),
    .trig_level(trig_s), .auto_eoi(aeoi_s), .nested_mode(nest_s), .spec_mask(smm_s),
    .sel_isr(sel_s), .ready(rdy_s), .cfg_err(err_s), .init_stb(init_s),
    .cmd_stb(cstb_s), .cmd_rotate(crot_s), .cmd_specific(cspec_s), .cmd_eoi(ceoi_s),
    .cmd_level(clvl_s), .ack_stb(ack_s), .ack_pin(apin_s));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic e, logic [7:0] d);
    @(negedge clk);
    addr = a; elc_sel = e; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, logic e);
    @(negedge clk);
    addr = a; elc_sel = e; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic init_seq(logic [7:0] w4);
    wr(0, 0, 8'h11);
    wr(1, 0, 8'h25);
    wr(1, 0, 8'h04);
    wr(1, 0, w4);
  endtask

  task automatic t_reset;
    check("R1 mask", mask_p, 8'hFF);
    check("R1 ready/err", {6'd0, rdy_p, err_p}, 8'h00);
    check("R1 trig", trig_p, 8'h00);
    check("R1 strobes", {5'd0, init_p, cstb_p, ack_p}, 8'h00);
    rd(1, 0);
    check("R10 reset mask read", rdata_p, 8'hFF);
  endtask

  task automatic t_not_ready_cmd;
    wr(0, 0, 8'h20);
    check("R7 no strobe before init", {7'd0, cstb_p}, 8'h00);
  endtask

  task automatic t_init;
    wr(0, 0, 8'h11);
    check("R2 init strobe", {7'd0, init_p}, 8'h01);
    check("R2 mask cleared", mask_p, 8'h00);
    check("R2 ready cleared", {7'd0, rdy_p}, 8'h00);
    wr(1, 0, 8'h25);
    check("R4 vector base", vec_p, 8'h20);
    wr(1, 0, 8'h04);
    check("R4 cascade word ignored", {vec_p[7:1], rdy_p}, {7'h10, 1'b0});
    check("R4 cascade word mask", mask_p, 8'h00);
    wr(1, 0, 8'h13);
    check("R5 ready", {6'd0, rdy_p, rdy_s}, 8'h03);
    check("R5 auto eoi", {7'd0, aeoi_p}, 8'h01);
    check("R5 nested primary/secondary", {6'd0, nest_p, nest_s}, 8'h02);
  endtask

  task automatic t_mask;
    wr(1, 0, 8'hA5);
    check("R6 mask load", mask_p, 8'hA5);
    rd(1, 0);
    check("R10 mask read", rdata_p, 8'hA5);
  endtask

  task automatic t_cmd;
    wr(0, 0, 8'hE3);
    check("R7 cmd fields", {2'd0, cstb_p, crot_p, cspec_p, ceoi_p, clvl_p[1:0]}, 8'h3F);
    check("R7 cmd level", {5'd0, clvl_p}, 8'h03);
    wr(0, 0, 8'h25);
    check("R7 eoi only", {3'd0, cstb_p, crot_p, cspec_p, ceoi_p, 1'b0}, 8'h12);
    @(negedge clk);
    check("R7 strobe one cycle", {7'd0, cstb_p}, 8'h00);
  endtask

  task automatic t_ocw3;
    wr(0, 0, 8'h68);
    check("R8 special mask set", {7'd0, smm_p}, 8'h01);
    wr(0, 0, 8'h28);
    check("R8 special mask needs enable", {7'd0, smm_p}, 8'h01);
    wr(0, 0, 8'h48);
    check("R8 special mask cleared", {7'd0, smm_p}, 8'h00);
    core_irr = 8'h5A; core_isr = 8'hC3;
    wr(0, 0, 8'h0B);
    rd(0, 0);
    check("R10 isr read", rdata_p, 8'hC3);
    wr(0, 0, 8'h0A);
    rd(0, 0);
    check("R10 irr read", rdata_p, 8'h5A);
  endtask

  task automatic t_poll;
    win_valid = 1'b1; win_pin = 3'd5;
    wr(0, 0, 8'h0E);
    rd(1, 0);
    check("R9 poll data", rdata_p, 8'h85);
    check("R9 poll ack", {4'd0, ack_p, apin_p}, 8'h0D);
    rd(1, 0);
    check("R9 poll cleared", rdata_p, 8'hA5);
    win_valid = 1'b0;
    wr(0, 0, 8'h0E);
    rd(0, 0);
    check("R9 poll empty", {rdata_p[6:0], ack_p}, 8'h00);
    check("R9 poll empty top bit", {7'd0, rdata_p[7]}, 8'h00);
  endtask

  task automatic t_errors;
    wr(0, 0, 8'h13);
    check("R3 single bit error", {6'd0, err_p, rdy_p}, 8'h02);
    wr(1, 0, 8'h3C);
    check("R3 data loads mask", mask_p, 8'h3C);
    check("R3 vector untouched", vec_p, 8'h20);
    wr(0, 0, 8'h20);
    check("R7 no strobe after error", {7'd0, cstb_p}, 8'h00);
    wr(1, 0, 8'h77);
    check("R12 sticky", {7'd0, err_p}, 8'h01);
    wr(0, 0, 8'h10);
    check("R3 missing word-4 bit", {7'd0, err_p}, 8'h01);
    wr(0, 0, 8'h11);
    check("R12 cleared by init", {7'd0, err_p}, 8'h00);
    wr(1, 0, 8'h25);
    wr(1, 0, 8'h04);
    wr(1, 0, 8'h02);
    check("R5 mode word error", {6'd0, err_p, rdy_p}, 8'h02);
    init_seq(8'h01);
    check("R5 clean init", {5'd0, err_p, rdy_p, aeoi_p}, 8'h02);
  endtask

  task automatic t_trig;
    wr(0, 1, 8'hFF);
    check("R11 primary mask", trig_p, 8'hF8);
    check("R11 secondary mask", trig_s, 8'hDE);
    rd(0, 1);
    check("R11 read primary", rdata_p, 8'hF8);
    check("R11 read secondary", rdata_s, 8'hDE);
    check("R11 port mask unaffected", mask_p, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_not_ready_cmd();
    t_init();
    t_mask();
    t_cmd();
    t_ocw3();
    t_poll();
    t_errors();
    t_trig();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule